// File: doc/BRIEF.md
# Raster Work Dispatcher for Parallel Pixel Engines

The block feeds a pool of identical per-pixel compute engines. It visits every pixel of an H×V screen in row-major order. For each pixel it produces the matching complex-plane point, using a start corner and separate real and imaginary step sizes. It then offers that point to the engines. Each engine drives a busy line. On any clock where at least one busy line is low, the block pulses the start line of the free engine with the smallest index, for exactly one cycle. In that same cycle it presents the point and the screen column and row. It then moves on to the next pixel.

A redraw request starts a full recompute of the frame. When the last pixel has been handed out and every engine has gone idle, the block raises a done flag. It also holds a clock count for the frame, which stays frozen for measuring throughput until the next redraw request. Points are built with adders only: one step per column, and a return to the left edge at each row change. The engine count and the screen size are parameters.

Top module: `work_dispatcher`

## Requirements
- R1: After reset, no start line is raised, `frame_done` is low and `frame_clocks` is zero, and this holds until `go` is seen.
- R2: At most one bit of `eng_start` is high in any cycle, and none is high once `frame_done` is set. In a start cycle, `pt_re`, `pt_im`, `pt_x` and `pt_y` describe the pixel being issued.
- R3: Bit i of `eng_start` and of `eng_busy` belongs to engine i. A start always goes to the lowest-indexed engine whose busy bit is low in that cycle.
- R4: In a cycle where every busy bit is high, no start is given and the pending pixel (column and row) is held for the next cycle.
- R5: Pixels are issued in row-major order. The column runs from 0 to H-1, then the row advances. The point is re = re0 + x·dre and im = im0 + y·dim in two's complement, wrapping modulo 2^32.
- R6: `frame_done` rises only after all H·V pixels have been issued, and only one cycle after the block has seen every busy bit low.
- R7: `go` clears `frame_clocks` at the edge where it is accepted. The count then rises by one at every later edge, up to and including the edge that sets `frame_done`. It stays constant, and `frame_done` stays high, until the next accepted `go`. With engines that never go busy, a frame counts H·V+1.
- R8: `go` is accepted only while idle or done. It latches the start corner and both steps and clears `frame_done`. A `go` during a running frame is ignored: the pixel sequence, the points and the count carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Redraw request |
| re_start | input | 32 | Real part of the top-left point (signed fixed point) |
| im_start | input | 32 | Imaginary part of the top-left point |
| re_step | input | 32 | Real increment per column |
| im_step | input | 32 | Imaginary increment per row |
| eng_busy | input | N_ENG | Busy line of each engine |
| eng_start | output | N_ENG | One-cycle start pulse per engine |
| pt_re | output | 32 | Real part of the pending point |
| pt_im | output | 32 | Imaginary part of the pending point |
| pt_x | output | $clog2(H_PIX) | Screen column of the pending pixel |
| pt_y | output | $clog2(V_PIX) | Screen row of the pending pixel |
| frame_done | output | 1 | Frame fully issued and all engines idle |
| frame_clocks | output | CNT_W | Clocks spent on the current or last frame |

## Verification
The engines are modelled with a fixed busy time per engine.

- **Zero busy time:** every pixel goes to engine 0 back to back. This exposes errors in the raster order, in the adder-built points and in the exact H·V+1 clock count.
- **Unequal busy times:** the grant moves between engines. This separates a true lowest-free pick from a rotating or highest-index one.
- **Long equal busy times:** all engines are busy for stretches. This shows whether the position is held or skipped.
- **Negative start points and steps:** these check signed accumulation.
- **A redraw request mid-frame:** the frame must not restart.

// File: rtl/mdisp_pkg.sv
package mdisp_pkg;

    localparam int COORD_W = 32;

    typedef logic signed [COORD_W-1:0] coord_t;

    typedef struct packed {
        coord_t re;
        coord_t im;
    } cplx_pt_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } disp_state_e;

    function automatic logic is_running(input disp_state_e s);
        return (s == ST_ISSUE) || (s == ST_DRAIN);
    endfunction

    function automatic logic can_accept_go(input disp_state_e s);
        return (s == ST_IDLE) || (s == ST_DONE);
    endfunction

endpackage

// File: rtl/mdisp_pick.sv
module mdisp_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] free_vec,
    output logic [N-1:0] grant,
    output logic         any_free
);
    logic [N:0] taken;

    assign taken[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_chain
            assign grant[i]   = free_vec[i] & ~taken[i];
            assign taken[i+1] = taken[i] | free_vec[i];
        end
    endgenerate

    assign any_free = taken[N];
endmodule

// File: rtl/mdisp_raster.sv
module mdisp_raster
    import mdisp_pkg::*;
#(
    parameter int H  = 320,
    parameter int V  = 240,
    localparam int XW = $clog2(H),
    localparam int YW = $clog2(V)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  logic     advance,
    input  coord_t   re0,
    input  coord_t   im0,
    input  coord_t   dre,
    input  coord_t   dim,
    output cplx_pt_t pt,
    output logic [XW-1:0] px,
    output logic [YW-1:0] py,
    output logic     last
);
    coord_t left_re;
    coord_t dre_q;
    coord_t dim_q;
    logic   row_end;

    assign row_end = (px == XW'(H - 1));
    assign last    = row_end && (py == YW'(V - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            px      <= '0;
            py      <= '0;
            pt      <= '0;
            left_re <= '0;
            dre_q   <= '0;
            dim_q   <= '0;
        end else if (load) begin
            px      <= '0;
            py      <= '0;
            pt.re   <= re0;
            pt.im   <= im0;
            left_re <= re0;
            dre_q   <= dre;
            dim_q   <= dim;
        end else if (advance) begin
            if (row_end) begin
                px    <= '0;
                pt.re <= left_re;
                if (!last) begin
                    py    <= py + YW'(1);
                    pt.im <= pt.im + dim_q;
                end
            end else begin
                px    <= px + XW'(1);
                pt.re <= pt.re + dre_q;
            end
        end
    end
endmodule

// File: rtl/mdisp_clkcount.sv
module mdisp_clkcount #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) count <= '0;
        else if (en)    count <= count + W'(1);
    end
endmodule

// File: rtl/work_dispatcher.sv
module work_dispatcher
    import mdisp_pkg::*;
#(
    parameter int N_ENG = 4,
    parameter int H_PIX = 320,
    parameter int V_PIX = 240,
    parameter int CNT_W = 24,
    localparam int XW = $clog2(H_PIX),
    localparam int YW = $clog2(V_PIX)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      go,
    input  logic signed [COORD_W-1:0] re_start,
    input  logic signed [COORD_W-1:0] im_start,
    input  logic signed [COORD_W-1:0] re_step,
    input  logic signed [COORD_W-1:0] im_step,
    input  logic [N_ENG-1:0]          eng_busy,
    output logic [N_ENG-1:0]          eng_start,
    output logic signed [COORD_W-1:0] pt_re,
    output logic signed [COORD_W-1:0] pt_im,
    output logic [XW-1:0]             pt_x,
    output logic [YW-1:0]             pt_y,
    output logic                      frame_done,
    output logic [CNT_W-1:0]          frame_clocks
);
    disp_state_e     state;
    logic            go_ok;
    logic            issue_ok;
    logic            any_free;
    logic            last_pix;
    logic [N_ENG-1:0] grant;
    cplx_pt_t        cur_pt;

    assign go_ok    = go && can_accept_go(state);
    assign issue_ok = (state == ST_ISSUE) && any_free;

    mdisp_pick #(.N(N_ENG)) u_pick (
        .free_vec (~eng_busy),
        .grant    (grant),
        .any_free (any_free)
    );

    mdisp_raster #(.H(H_PIX), .V(V_PIX)) u_raster (
        .clk     (clk),
        .rst     (rst),
        .load    (go_ok),
        .advance (issue_ok),
        .re0     (re_start),
        .im0     (im_start),
        .dre     (re_step),
        .dim     (im_step),
        .pt      (cur_pt),
        .px      (pt_x),
        .py      (pt_y),
        .last    (last_pix)
    );

    mdisp_clkcount #(.W(CNT_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .clr   (go_ok),
        .en    (is_running(state)),
        .count (frame_clocks)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE: if (go_ok) state <= ST_ISSUE;
                ST_ISSUE: if (issue_ok && last_pix) state <= ST_DRAIN;
                ST_DRAIN: if (eng_busy == '0) state <= ST_DONE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign eng_start  = issue_ok ? grant : '0;
    assign pt_re      = cur_pt.re;
    assign pt_im      = cur_pt.im;
    assign frame_done = (state == ST_DONE);
endmodule

// File: rtl/mdisp_checker.sv
module mdisp_checker #(
    parameter int N     = 4,
    parameter int XW    = 9,
    parameter int YW    = 8,
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             go,
    input logic [N-1:0]     eng_busy,
    input logic [N-1:0]     eng_start,
    input logic [XW-1:0]    pt_x,
    input logic [YW-1:0]    pt_y,
    input logic             frame_done,
    input logic [CNT_W-1:0] frame_clocks
);
    a_r2_single_start: assert property (@(posedge clk) disable iff (rst)
        $onehot0(eng_start));

    a_r2_no_start_when_done: assert property (@(posedge clk) disable iff (rst)
        (eng_start != '0) |-> !frame_done);

    a_r3_never_busy_target: assert property (@(posedge clk) disable iff (rst)
        (eng_start & eng_busy) == '0);

    a_r3_lowest_free: assert property (@(posedge clk) disable iff (rst)
        (eng_start != '0) |-> (((eng_start - N'(1)) & ~eng_busy) == '0));

    a_r4_hold_when_full: assert property (@(posedge clk) disable iff (rst)
        ((&eng_busy) && !go) |=> ($stable(pt_x) && $stable(pt_y)));

    a_r6_done_after_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_done) |-> ($past(eng_busy) == '0));

    a_r7_count_frozen: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !go) |=> ($stable(frame_clocks) && frame_done));
endmodule

bind work_dispatcher mdisp_checker #(
    .N(N_ENG), .XW(XW), .YW(YW), .CNT_W(CNT_W)
) u_mdisp_checker (
    .clk          (clk),
    .rst          (rst),
    .go           (go),
    .eng_busy     (eng_busy),
    .eng_start    (eng_start),
    .pt_x         (pt_x),
    .pt_y         (pt_y),
    .frame_done   (frame_done),
    .frame_clocks (frame_clocks)
);

// File: tb/tb_work_dispatcher.sv
`timescale 1ns/1ps
module tb_work_dispatcher;
    localparam int N  = 4;
    localparam int H  = 8;
    localparam int V  = 6;
    localparam int CW = 24;
    localparam int XW = $clog2(H);
    localparam int YW = $clog2(V);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go  = 1'b0;
    logic signed [31:0] re_start = '0, im_start = '0, re_step = '0, im_step = '0;
    logic [N-1:0]  eng_busy;
    logic [N-1:0]  eng_start;
    logic signed [31:0] pt_re, pt_im;
    logic [XW-1:0] pt_x;
    logic [YW-1:0] pt_y;
    logic          frame_done;
    logic [CW-1:0] frame_clocks;

    always #2.5 clk = ~clk;

    work_dispatcher #(.N_ENG(N), .H_PIX(H), .V_PIX(V), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .go(go),
        .re_start(re_start), .im_start(im_start),
        .re_step(re_step), .im_step(im_step),
        .eng_busy(eng_busy), .eng_start(eng_start),
        .pt_re(pt_re), .pt_im(pt_im), .pt_x(pt_x), .pt_y(pt_y),
        .frame_done(frame_done), .frame_clocks(frame_clocks)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // engine model: busy for lat[i] cycles after a start
    int lat [N];
    int cnt [N];
    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) cnt[i] <= 0;
            else if (eng_start[i]) cnt[i] <= lat[i];
            else if (cnt[i] > 0) cnt[i] <= cnt[i] - 1;
        end
    end
    always_comb begin
        for (int i = 0; i < N; i++) eng_busy[i] = (cnt[i] != 0);
    end

    // expected raster state
    logic signed [31:0] e_re0, e_im0, e_dre, e_dim;
    int ex = 0, ey = 0, issued = 0;
    bit prev_done = 0;
    bit held_valid = 0;
    int held_x, held_y;

    function automatic logic [N-1:0] lowest_free(input logic [N-1:0] b);
        logic [N-1:0] r = '0;
        for (int i = N - 1; i >= 0; i--) if (!b[i]) r = N'(1) << i;
        return r;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            logic signed [31:0] wre, wim;
            if (held_valid) begin
                chk(pt_x == held_x && pt_y == held_y, "R4", {pt_y, pt_x}, held_y * 256 + held_x);
                held_valid = 0;
            end
            if (&eng_busy) begin
                chk(eng_start == '0, "R4", eng_start, 0);
                held_valid = 1; held_x = pt_x; held_y = pt_y;
            end
            if (eng_start != '0) begin
                wre = e_re0 + 32'(ex) * e_dre;
                wim = e_im0 + 32'(ey) * e_dim;
                chk(eng_start == lowest_free(eng_busy), "R3", eng_start, lowest_free(eng_busy));
                chk(int'(pt_x) == ex && int'(pt_y) == ey, "R5", pt_y * 256 + pt_x, ey * 256 + ex);
                chk(pt_re == wre && pt_im == wim, "R5", pt_re, wre);
                chk(!frame_done, "R2", frame_done, 0);
                issued++;
                if (ex == H - 1) begin ex = 0; ey++; end
                else ex++;
            end
            if (frame_done && !prev_done)
                chk(eng_busy == '0 && issued == H * V, "R6", issued, H * V);
            prev_done = frame_done;
        end
    end

    // run one frame; optionally pulse go again with junk values at cycle again_at
    task automatic run_frame(input logic signed [31:0] r0, i0, dr, di,
                             input int again_at, output int cycles);
        @(negedge clk);
        e_re0 = r0; e_im0 = i0; e_dre = dr; e_dim = di;
        ex = 0; ey = 0; issued = 0;
        re_start = r0; im_start = i0; re_step = dr; im_step = di;
        go = 1'b1;
        @(posedge clk);
        @(negedge clk);
        go = 1'b0;
        re_start = 32'sd999; im_start = -32'sd999; re_step = 32'sd77; im_step = 32'sd55;
        chk(frame_clocks == '0 && !frame_done, "R7", frame_clocks, 0);
        cycles = 0;
        while (!frame_done && cycles < 20000) begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
            go = (cycles == again_at);
        end
        go = 1'b0;
        chk(frame_done, "R6", frame_done, 1);
        chk(int'(frame_clocks) == cycles, "R7", frame_clocks, cycles);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk(eng_start == '0, "R1", eng_start, 0);
        chk(!frame_done, "R1", frame_done, 0);
        chk(frame_clocks == '0, "R1", frame_clocks, 0);
    endtask

    task automatic t_all_free();
        int c;
        for (int i = 0; i < N; i++) lat[i] = 0;
        run_frame(32'sd100, 32'sd50, 32'sd3, 32'sd7, -1, c);
        chk(c == H * V + 1, "R7", c, H * V + 1);
        chk(issued == H * V, "R5", issued, H * V);
    endtask

    task automatic t_mixed();
        int c;
        lat[0] = 3; lat[1] = 5; lat[2] = 2; lat[3] = 7;
        run_frame(-32'sd400, 32'sd20, 32'sd11, -32'sd13, -1, c);
        chk(issued == H * V, "R3", issued, H * V);
    endtask

    task automatic t_stall();
        int c;
        for (int i = 0; i < N; i++) lat[i] = 12;
        run_frame(32'sd5, 32'sd6, 32'sd1, 32'sd1, -1, c);
        chk(c > H * V + 1, "R4", c, H * V + 2);
    endtask

    task automatic t_go_ignored();
        int c;
        for (int i = 0; i < N; i++) lat[i] = 0;
        run_frame(-32'sd1000, -32'sd2000, -32'sd9, 32'sd4, 10, c);
        chk(c == H * V + 1, "R8", c, H * V + 1);
        chk(issued == H * V, "R8", issued, H * V);
    endtask

    task automatic t_freeze();
        logic [CW-1:0] snap;
        snap = frame_clocks;
        repeat (10) @(negedge clk);
        chk(frame_clocks == snap, "R7", frame_clocks, snap);
        chk(frame_done, "R7", frame_done, 1);
        chk(eng_start == '0, "R2", eng_start, 0);
    endtask

    task automatic t_wrap();
        int c;
        lat[0] = 1; lat[1] = 0; lat[2] = 4; lat[3] = 0;
        run_frame(32'sh7FFF_FFF0, -32'sh7FFF_FFF0, 32'sd5, -32'sd9, -1, c);
        chk(issued == H * V, "R5", issued, H * V);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) lat[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_all_free();
        t_freeze();
        t_mixed();
        t_stall();
        t_go_ignored();
        t_wrap();
        t_freeze();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule